// File: doc/BRIEF.md
# Parameter Memory Access Unit

This block sits between a channel processor and a shared, word-addressed parameter RAM. Each parameter is one 32-bit word, which is four bytes in the host's byte map. Each channel owns a region of the RAM that starts at a base address, and software programs that base during initialisation. Channels may use regions of different sizes. An access names a channel and a parameter index. The unit adds the index to that channel's base to form the RAM word address.

All data passes through a 32-bit preload register. A write stores the preload register into the RAM. A read loads the RAM word back into the preload register. Each access chooses one of three sizes: the whole word, only the top byte, or only the low 24 bits. The size can change from one access to the next with no gap between them. A 24-bit read can sign-extend from bit 23 or fill the top byte with zeros. The RAM is synchronous and single-cycle, so read data appears one clock after the request.

Top module: `param_access_unit`

## Requirements
- R1: Size code 2'b00 (and the reserved code 2'b11) is a full-word access. A write drives byte enables 4'b1111 and the whole preload register. A read returns all 32 RAM bits.
- R2: Size code 2'b01 is an upper-byte access. A write drives byte enables 4'b1000, so only bits [31:24] of the RAM word change.
- R3: Size code 2'b10 is a 24-bit access. A write drives byte enables 4'b0111, so only bits [23:0] of the RAM word change.
- R4: An upper-byte read puts RAM bits [31:24] into result bits [31:24]. Result bits [23:0] keep the current preload value.
- R5: A 24-bit read with the sign-extend input low returns RAM bits [23:0] with bits [31:24] set to zero.
- R6: A 24-bit read with the sign-extend input high copies RAM bit 23 into result bits [31:24].
- R7: The RAM word address is the base of the selected channel plus the index, truncated to the RAM address width. Every base resets to zero.
- R8: A base write takes effect on the next access. An access in the same cycle as the base write still uses the old base.
- R9: A read issued in cycle t drives `rd_valid` high and the result on `rd_data` in cycle t+1. From cycle t+2 the preload register holds that result.
- R10: Accesses of different sizes can follow each other on consecutive cycles, and each one returns its own correct result.
- R11: A preload load (`pre_we`) updates the preload register on the next clock. If a read result lands in the same cycle, the read result takes priority and the load is dropped.
- R12: After reset, `pre_q` is zero and `rd_valid` is low. When `req` is low, `ram_en` is low and `ram_be` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Write a channel base address |
| base_ch | input | CW | Channel whose base is written |
| base_wdata | input | AW | New base word address |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write the preload register to the RAM, 0 = read |
| req_ch | input | CW | Channel of the access |
| req_idx | input | IW | Parameter index inside the channel region |
| req_size | input | 2 | 00 full, 01 upper byte, 10 low 24 bits, 11 full |
| req_sext | input | 1 | Sign-extend a 24-bit read |
| pre_we | input | 1 | Load the preload register from `pre_d` |
| pre_d | input | 32 | Preload load data |
| pre_q | output | 32 | Preload register |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 32 | Merged read result |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write |
| ram_be | output | 4 | RAM byte-lane write enables, bit 3 = bits [31:24] |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one clock after the address |

## Verification
The unit holds two kinds of state: the table of channel bases and the size and sign-extend settings of the read in flight.

A wrong base entry shows on `ram_addr` in the same cycle as the next access to that channel.

A wrong record of the read in flight shows on `rd_data` one cycle after the request, as a wrong top byte or wrong low lanes. The bench mixes access sizes back to back, so a record taken from the wrong request is exposed at once. It also writes data with distinct bytes, so a lane that leaks or a sign bit taken from the wrong place changes a value that is read back later.

// File: rtl/param_access_unit.sv
module param_access_unit #(
  parameter int NCH = 8,
  parameter int AW  = 10,
  parameter int IW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [CW-1:0] base_ch,
  input  logic [AW-1:0] base_wdata,
  input  logic          req,
  input  logic          req_wr,
  input  logic [CW-1:0] req_ch,
  input  logic [IW-1:0] req_idx,
  input  logic [1:0]    req_size,
  input  logic          req_sext,
  input  logic          pre_we,
  input  logic [31:0]   pre_d,
  output logic [31:0]   pre_q,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          ram_en,
  output logic          ram_we,
  output logic [3:0]    ram_be,
  output logic [AW-1:0] ram_addr,
  output logic [31:0]   ram_wdata,
  input  logic [31:0]   ram_rdata
);

  localparam logic [1:0] SZ_UPPER = 2'b01;
  localparam logic [1:0] SZ_LOW24 = 2'b10;

  logic [AW-1:0] base_q [NCH];
  logic [1:0]    land_size;
  logic          land_sext;
  logic [3:0]    lane_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) base_q[i] <= '0;
    end else if (base_we) begin
      base_q[base_ch] <= base_wdata;
    end
  end

  assign ram_addr  = base_q[req_ch] + AW'(req_idx);
  assign ram_en    = req;
  assign ram_we    = req & req_wr;
  assign ram_wdata = pre_q;

  always_comb begin
    case (req_size)
      SZ_UPPER: lane_mask = 4'b1000;
      SZ_LOW24: lane_mask = 4'b0111;
      default:  lane_mask = 4'b1111;
    endcase
  end

  assign ram_be = ram_we ? lane_mask : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      land_size <= 2'b00;
      land_sext <= 1'b0;
    end else begin
      rd_valid <= req & ~req_wr;
      if (req & ~req_wr) begin
        land_size <= req_size;
        land_sext <= req_sext;
      end
    end
  end

  always_comb begin
    case (land_size)
      SZ_UPPER: rd_data = {ram_rdata[31:24], pre_q[23:0]};
      SZ_LOW24: rd_data = {land_sext ? {8{ram_rdata[23]}} : 8'h00, ram_rdata[23:0]};
      default:  rd_data = ram_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (rd_valid) pre_q <= rd_data;
    else if (pre_we)   pre_q <= pre_d;
  end

endmodule

// File: rtl/param_access_unit_chk.sv
module param_access_unit_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          req_wr,
  input logic [1:0]    req_size,
  input logic          req_sext,
  input logic [31:0]   pre_q,
  input logic          rd_valid,
  input logic [31:0]   rd_data,
  input logic          ram_en,
  input logic [3:0]    ram_be,
  input logic [AW-1:0] ram_addr
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_wr) |=> rd_valid); // R9

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !req_wr) |=> !rd_valid); // R9

  AST_PRE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (pre_q == $past(rd_data))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!ram_en && ram_be == 4'b0000)); // R12

  AST_UPPER_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_wr && req_size == 2'b01) |-> (ram_be == 4'b1000)); // R2

  AST_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_wr && req_size == 2'b10) |-> (ram_be == 4'b0111)); // R3

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_size) == 2'b01) |-> (rd_data[23:0] == pre_q[23:0])); // R4

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_size) == 2'b10 && !$past(req_sext)) |-> (rd_data[31:24] == 8'h00)); // R5

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_size) == 2'b10 && $past(req_sext)) |-> (rd_data[31:24] == {8{rd_data[23]}})); // R6

  AST_ADDR_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !$isunknown(ram_addr)); // R7

endmodule

bind param_access_unit param_access_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_size(req_size),
  .req_sext(req_sext), .pre_q(pre_q), .rd_valid(rd_valid), .rd_data(rd_data),
  .ram_en(ram_en), .ram_be(ram_be), .ram_addr(ram_addr)
);

// File: tb/param_access_unit_bench.sv
module param_access_unit_bench;
  localparam int NCH = 8;
  localparam int AW  = 10;
  localparam int IW  = 8;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [CW-1:0] base_ch = '0;
  logic [AW-1:0] base_wdata = '0;
  logic req = 1'b0, req_wr = 1'b0, req_sext = 1'b0;
  logic [CW-1:0] req_ch = '0;
  logic [IW-1:0] req_idx = '0;
  logic [1:0] req_size = 2'b00;
  logic pre_we = 1'b0;
  logic [31:0] pre_d = '0;
  logic [31:0] pre_q, rd_data, ram_wdata, ram_rdata;
  logic rd_valid, ram_en, ram_we;
  logic [3:0] ram_be;
  logic [AW-1:0] ram_addr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  param_access_unit #(.NCH(NCH), .AW(AW), .IW(IW)) u_param_access_unit (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_ch(base_ch), .base_wdata(base_wdata),
    .req(req), .req_wr(req_wr), .req_ch(req_ch), .req_idx(req_idx), .req_size(req_size),
    .req_sext(req_sext), .pre_we(pre_we), .pre_d(pre_d), .pre_q(pre_q), .rd_valid(rd_valid),
    .rd_data(rd_data), .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [31:0] mem [1 << AW];
  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we)
        for (int b = 0; b < 4; b++)
          if (ram_be[b]) mem[ram_addr][b*8 +: 8] <= ram_wdata[b*8 +: 8];
      ram_rdata <= mem[ram_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pre(input logic [31:0] v);
    @(negedge clk); pre_we = 1'b1; pre_d = v;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic set_base(input int ch, input int b);
    @(negedge clk); base_we = 1'b1; base_ch = CW'(ch); base_wdata = AW'(b);
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic access(input logic wr, input int ch, input int idx, input logic [1:0] sz,
                        input logic sx, output logic [AW-1:0] a, output logic [3:0] be,
                        output logic v, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_ch = CW'(ch); req_idx = IW'(idx); req_size = sz; req_sext = sx;
    #1; a = ram_addr; be = ram_be;
    @(negedge clk);
    req = 1'b0; req_wr = 1'b0;
    v = rd_valid; d = rd_data;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 reset pre_q", pre_q, 32'h0);
    chk("R12 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    chk("R12 idle ram_en", {31'b0, ram_en}, 32'h0);
    chk("R12 idle ram_be", {28'b0, ram_be}, 32'h0);
  endtask

  task automatic t_full();
    logic [AW-1:0] a; logic [3:0] be; logic v; logic [31:0] d;
    set_base(2, 100);
    set_pre(32'hA5C3_1234);
    access(1'b1, 2, 0, 2'b00, 1'b0, a, be, v, d);
    chk("R7 address base+idx", {22'b0, a}, 32'd100);
    chk("R1 full write lanes", {28'b0, be}, 32'hF);
    chk("R9 no valid after write", {31'b0, v}, 32'h0);
    set_pre(32'h0);
    access(1'b0, 2, 0, 2'b00, 1'b0, a, be, v, d);
    chk("R9 read valid", {31'b0, v}, 32'h1);
    chk("R1 full read data", d, 32'hA5C3_1234);
    chk("R9 preload holds read", pre_q, 32'hA5C3_1234);
    set_pre(32'h0);
    access(1'b0, 2, 0, 2'b11, 1'b0, a, be, v, d);
    chk("R1 reserved code reads full", d, 32'hA5C3_1234);
  endtask

  task automatic t_lanes();
    logic [AW-1:0] a; logic [3:0] be; logic v; logic [31:0] d;
    set_pre(32'h7E00_0000);
    access(1'b1, 2, 0, 2'b01, 1'b0, a, be, v, d);
    chk("R2 upper write lanes", {28'b0, be}, 32'h8);
    set_pre(32'h0);
    access(1'b0, 2, 0, 2'b00, 1'b0, a, be, v, d);
    chk("R2 upper write only top byte", d, 32'h7EC3_1234);
    set_pre(32'h11AB_CDEF);
    access(1'b1, 2, 0, 2'b10, 1'b0, a, be, v, d);
    chk("R3 low24 write lanes", {28'b0, be}, 32'h7);
    access(1'b0, 2, 0, 2'b00, 1'b0, a, be, v, d);
    chk("R3 low24 write keeps top byte", d, 32'h7EAB_CDEF);
  endtask

  task automatic t_reads();
    logic [AW-1:0] a; logic [3:0] be; logic v; logic [31:0] d;
    set_pre(32'hFFFF_FFFF);
    access(1'b0, 2, 0, 2'b10, 1'b0, a, be, v, d);
    chk("R5 low24 read zero fill", d, 32'h00AB_CDEF);
    access(1'b0, 2, 0, 2'b10, 1'b1, a, be, v, d);
    chk("R6 low24 read sign fill ones", d, 32'hFFAB_CDEF);
    set_pre(32'h0011_2233);
    access(1'b0, 2, 0, 2'b01, 1'b0, a, be, v, d);
    chk("R4 upper read merge", d, 32'h7E11_2233);
    chk("R4 preload after upper read", pre_q, 32'h7E11_2233);
    set_pre(32'h0);
    access(1'b1, 2, 1, 2'b00, 1'b0, a, be, v, d);
    chk("R7 next index address", {22'b0, a}, 32'd101);
    set_pre(32'h9912_3456);
    access(1'b1, 2, 1, 2'b10, 1'b0, a, be, v, d);
    set_pre(32'hFFFF_FFFF);
    access(1'b0, 2, 1, 2'b10, 1'b1, a, be, v, d);
    chk("R6 low24 read sign fill zeros", d, 32'h0012_3456);
  endtask

  task automatic t_addr();
    logic [AW-1:0] a; logic [3:0] be; logic v; logic [31:0] d;
    set_base(5, 1020);
    access(1'b0, 5, 10, 2'b00, 1'b0, a, be, v, d);
    chk("R7 address wraps", {22'b0, a}, 32'd6);
    set_base(1, 50);
    @(negedge clk);
    base_we = 1'b1; base_ch = 3'd1; base_wdata = 10'd200;
    req = 1'b1; req_wr = 1'b0; req_ch = 3'd1; req_idx = '0; req_size = 2'b00; req_sext = 1'b0;
    #1; chk("R8 same-cycle access uses old base", {22'b0, ram_addr}, 32'd50);
    @(negedge clk);
    base_we = 1'b0;
    #1; chk("R8 next access uses new base", {22'b0, ram_addr}, 32'd200);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_b2b();
    set_pre(32'h0055_6677);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_ch = 3'd2; req_idx = '0; req_size = 2'b01; req_sext = 1'b0;
    @(negedge clk);
    chk("R10 b2b upper result", rd_data, 32'h7E55_6677);
    req_size = 2'b10; req_sext = 1'b1;
    @(negedge clk);
    chk("R10 b2b low24 sign result", rd_data, 32'hFFAB_CDEF);
    req_size = 2'b00; req_sext = 1'b0;
    @(negedge clk);
    chk("R10 b2b full result", rd_data, 32'h7EAB_CDEF);
    req = 1'b0;
    @(negedge clk);
    chk("R10 b2b valid drops", {31'b0, rd_valid}, 32'h0);
    chk("R9 preload after b2b", pre_q, 32'h7EAB_CDEF);
  endtask

  task automatic t_priority();
    set_pre(32'h0);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_ch = 3'd2; req_idx = '0; req_size = 2'b00; req_sext = 1'b0;
    @(negedge clk);
    req = 1'b0; pre_we = 1'b1; pre_d = 32'hDEAD_BEEF;
    @(negedge clk);
    pre_we = 1'b0;
    chk("R11 read wins over load", pre_q, 32'h7EAB_CDEF);
    set_pre(32'hDEAD_BEEF);
    chk("R11 plain load", pre_q, 32'hDEAD_BEEF);
    chk("R12 idle after traffic", {31'b0, ram_en}, 32'h0);
  endtask

  task automatic run_all();
    #35 rst_n = 1'b1;
    t_reset();
    t_full();
    t_lanes();
    t_reads();
    t_addr();
    t_b2b();
    t_priority();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule